// File: doc/BRIEF.md
# SPI Controller with Inter-Word Select Gap

This block is a serial peripheral interface controller. It sends words from a small transmit FIFO. It supports every combination of clock polarity and clock phase, and the word length is set at run time. Software-style writes place words in the transmit queue. The controller sends them most significant bit first. At the same time it shifts in the reply on `miso` and pushes each complete reply word into a receive queue, where it can be read at any later time.

Back-to-back words are not sent seamlessly. With phase 0, the select line is raised between every pair of words, even when the next word is already waiting. The select line stays high for three half periods of the serial clock. With phase 1, the select line stays low and the controller inserts a single idle half period before each word. The serial clock is an even division of the system clock, so its rate is at most half the system clock rate.

The clock polarity, clock phase, word length and divider settings are expected to stay constant while `busy` is high.

Top module: `spi_gap_ctrl`

## Requirements
- R1: After reset, `cs_n` is 1, `busy` is 0, `mosi` is 0, `sck` equals `cpol`, `tx_full` is 0 and `rx_empty` is 1.
- R2: While deselected, `sck` rests at the level of `cpol`. The sampling edge is the first edge of each bit when `cpha`=0 and the second edge when `cpha`=1. `mosi` changes only on the other edge, so it is stable at every sampling edge.
- R3: `word_len` gives the number of bits per word, from 4 to 16. The low `word_len` bits of the written data are sent most significant bit first.
- R4: Each half period of `sck` lasts `div_half` system clock cycles, with `div_half` of 1 or more. The serial clock period is therefore an even number of cycles, and never less than 2.
- R5: With `cpha`=0, `cs_n` goes high for exactly 3 half periods between two queued words.
- R6: With `cpha`=1, `cs_n` stays low across queued words. One idle half period precedes each word, including the first.
- R7: `busy` is high from the start of the first word until the last word ends. For two queued words of N bits this takes (4N+3)·`div_half` cycles with `cpha`=0 and (4N+2)·`div_half` cycles with `cpha`=1. `cs_n` is 1 whenever `busy` is 0.
- R8: The transmit FIFO holds 4 words, and `tx_full` reports when it has none free. A write while it is full is ignored.
- R9: Each received word is pushed into a 4-entry receive FIFO, right-aligned and zero-extended. `rd_data` shows the oldest word, and `rd_en` removes it. A word that arrives while the receive FIFO is full is dropped.
- R10: When the transmit FIFO is empty at the end of a word, the controller raises `cs_n`, returns `sck` to its idle level and drops `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the transmit FIFO |
| wr_data | input | 16 | Word to send, right-aligned |
| tx_full | output | 1 | Transmit FIFO has no free entry |
| cpol | input | 1 | Clock polarity: idle level of `sck` |
| cpha | input | 1 | Clock phase: 0 samples on the first edge, 1 on the second |
| word_len | input | 5 | Bits per word, 4 to 16 |
| div_half | input | 8 | System cycles per half period of `sck` |
| rd_en | input | 1 | Removes the oldest received word |
| rd_data | output | 16 | Oldest received word |
| rx_empty | output | 1 | Receive FIFO holds no word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench models a peripheral that latches `mosi` and drives `miso` on the edges the mode defines, and it measures both the select-high time and the busy time of two-word bursts. A design that used the wrong gap length, or that pulsed the select line in phase 1, changes these cycle counts. A swapped sampling edge corrupts the captured words. An off-by-one in the word length shifts the bit count. A separate burst overfills both FIFOs. Any design that accepts a write while full, or overwrites a held receive word, then sends an extra word or returns the wrong oldest reply.

// File: rtl/spi_gap_pkg.sv
// Shared types and constants for the SPI controller.
// Assumes nothing beyond IEEE 1800-2017.
package spi_gap_pkg;

    // Engine sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_WORD = 2'd2
    } eng_state_t;

    // Length of the inter-word pause in half periods, minus one
    localparam logic [1:0] GAP_LAST_PH0 = 2'd2;
    localparam logic [1:0] GAP_LAST_PH1 = 2'd0;

    // Shortest word the engine will shift
    localparam int MIN_WORD_BITS = 4;

endpackage

// File: rtl/spi_gap_fifo.sv
// Synchronous first-word-fall-through queue.
// head shows the oldest entry. A push while full is ignored, unless a pop
// happens in the same cycle, and a pop while empty is ignored.
// Assumes DEPTH is a power of two.
module spi_gap_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rp];

    // Store incoming words
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    // Track read/write positions and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (full && $stable(wp))); // R8

endmodule

// File: rtl/spi_gap_engine.sv
// Serial shift engine.
// It pulls words from the transmit queue and shifts them out most
// significant bit first on sck/mosi, while sampling miso. It inserts the
// inter-word pause that the clock phase requires: select high for three half
// periods with phase 0, or one idle half period with select held low with
// phase 1. Assumes the configuration inputs stay stable while busy is high.
module spi_gap_engine
    import spi_gap_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    localparam int LEN_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [DIV_W-1:0]  div_half,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_head,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic              busy
);
    localparam int HW = LEN_W + 1;

    eng_state_t        st;
    logic [DIV_W-1:0]  cnt;
    logic [HW-1:0]     hidx;
    logic [1:0]        gcnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] rxsh;
    logic              sck_r, cs_r;

    logic [DIV_W-1:0]  div_eff;
    logic [LEN_W-1:0]  len_eff;
    logic [HW-1:0]     half_max, hnext;
    logic [1:0]        gap_last;
    logic              half_end, half_last, gap_done;

    // Clamp settings to their legal ranges
    assign div_eff  = (div_half == '0) ? DIV_W'(1) : div_half;
    assign len_eff  = (word_len < LEN_W'(MIN_WORD_BITS)) ? LEN_W'(MIN_WORD_BITS) :
                      (word_len > LEN_W'(DATA_W))        ? LEN_W'(DATA_W) : word_len;
    assign half_max  = {len_eff, 1'b0} - HW'(1);
    assign hnext     = hidx + HW'(1);
    assign gap_last  = cpha ? GAP_LAST_PH1 : GAP_LAST_PH0;
    assign half_end  = (cnt == div_eff - DIV_W'(1));
    assign half_last = (hidx == half_max);
    assign gap_done  = half_end && (gcnt == gap_last);

    // Queue handshakes and pin outputs
    assign tx_pop  = ((st == ST_IDLE) && !tx_empty && !cpha) ||
                     ((st == ST_GAP) && gap_done);
    assign rx_push = (st == ST_WORD) && half_end && half_last;
    assign rx_word = rxsh;
    assign mosi    = (st == ST_WORD) ? shreg[DATA_W-1] : 1'b0;
    assign sck     = (st == ST_IDLE) ? cpol : sck_r;
    assign cs_n    = cs_r;
    assign busy    = (st != ST_IDLE);

    // Sequence idle, pause and word phases at half-period granularity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            hidx  <= '0;
            gcnt  <= '0;
            shreg <= '0;
            rxsh  <= '0;
            sck_r <= 1'b0;
            cs_r  <= 1'b1;
        end else begin
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (!tx_empty) begin
                        cs_r  <= 1'b0;
                        sck_r <= cpol;
                        if (cpha) begin
                            st   <= ST_GAP;
                            gcnt <= '0;
                        end else begin
                            st    <= ST_WORD;
                            hidx  <= '0;
                            shreg <= tx_head << (LEN_W'(DATA_W) - len_eff);
                            rxsh  <= '0;
                        end
                    end
                end
                ST_GAP: begin
                    if (half_end) begin
                        cnt <= '0;
                        if (gap_done) begin
                            st    <= ST_WORD;
                            hidx  <= '0;
                            shreg <= tx_head << (LEN_W'(DATA_W) - len_eff);
                            rxsh  <= '0;
                            cs_r  <= 1'b0;
                            sck_r <= cpol ^ cpha;
                        end else begin
                            gcnt <= gcnt + 2'd1;
                        end
                    end else begin
                        cnt <= cnt + DIV_W'(1);
                    end
                end
                ST_WORD: begin
                    if (half_end) begin
                        cnt <= '0;
                        if (half_last) begin
                            sck_r <= cpol;
                            if (!tx_empty) begin
                                st   <= ST_GAP;
                                gcnt <= '0;
                                cs_r <= !cpha;
                            end else begin
                                st   <= ST_IDLE;
                                cs_r <= 1'b1;
                            end
                        end else begin
                            hidx  <= hnext;
                            sck_r <= cpol ^ cpha ^ hnext[0];
                            if (hnext[0]) rxsh  <= {rxsh[DATA_W-2:0], miso};
                            else          shreg <= shreg << 1;
                        end
                    end else begin
                        cnt <= cnt + DIV_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R8

    AST_MOSI_STABLE_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_WORD) && $past(st == ST_WORD) && (sck_r != $past(sck_r)) &&
         (sck_r == (cpol ^ !cpha))) |-> $stable(mosi)); // R2

endmodule

// File: rtl/spi_gap_ctrl.sv
// Top level of the SPI controller with the phase-dependent inter-word gap.
// It joins a transmit FIFO, the shift engine and a receive FIFO.
// Assumes cpol, cpha, word_len and div_half stay stable while busy is high.
module spi_gap_ctrl #(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    output logic                         tx_full,
    input  logic                         cpol,
    input  logic                         cpha,
    input  logic [$clog2(DATA_W+1)-1:0]  word_len,
    input  logic [DIV_W-1:0]             div_half,
    input  logic                         rd_en,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rx_empty,
    output logic                         sck,
    output logic                         mosi,
    input  logic                         miso,
    output logic                         cs_n,
    output logic                         busy
);
    logic              tx_empty, tx_pop, rx_push, rx_full_unused;
    logic [DATA_W-1:0] tx_head, rx_word;

    spi_gap_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spi_gap_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
        .word_len(word_len), .div_half(div_half),
        .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy)
    );

    spi_gap_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
        .pop(rd_en), .head(rd_data), .full(rx_full_unused), .empty(rx_empty)
    );

    AST_DESELECT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n); // R7

    AST_SCK_REST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sck == cpol)); // R2

    AST_PH1_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && cpha) |-> !cs_n); // R6

endmodule

// File: tb/spi_gap_ctrl_tb.sv
module spi_gap_ctrl_tb;
    typedef struct packed {
        logic        cpol;
        logic        cpha;
        logic [4:0]  len;
        logic [7:0]  div;
        logic [15:0] w0, w1, s0, s1;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 5'd8,  8'd1, 16'h00A5, 16'h003C, 16'h0096, 16'h000F},
        '{1'b1, 1'b1, 5'd8,  8'd2, 16'h0081, 16'h007E, 16'h005A, 16'h00C3},
        '{1'b0, 1'b1, 5'd16, 8'd1, 16'hBEEF, 16'h1234, 16'hCAFE, 16'h8001},
        '{1'b1, 1'b0, 5'd12, 8'd3, 16'h0ABC, 16'h0123, 16'h0FED, 16'h000F},
        '{1'b0, 1'b0, 5'd4,  8'd2, 16'h0009, 16'h0006, 16'h0003, 16'h000C}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic [15:0] wr_data = '0;
    logic [4:0]  word_len = 5'd8;
    logic [7:0]  div_half = 8'd1;
    logic        tx_full, rx_empty, sck, mosi, miso, cs_n, busy;
    logic [15:0] rd_data;

    spi_gap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_full(tx_full), .cpol(cpol), .cpha(cpha), .word_len(word_len),
        .div_half(div_half), .rd_en(rd_en), .rd_data(rd_data),
        .rx_empty(rx_empty), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .busy(busy)
    );

    always #10 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0;
    int cur_len = 8;
    logic [15:0] sl_w [8];
    logic [15:0] cap_w [8];
    int sbit = 0, busy_cyc = 0, cs_hi_cyc = 0;
    logic mon_clr = 1'b1, sck_prev = 1'b0;

    // Peripheral model: presents the next reply bit according to the bit count
    always_comb begin
        miso = 1'b0;
        if (cur_len > 0 && (sbit / cur_len) < 8)
            miso = sl_w[sbit / cur_len][cur_len - 1 - (sbit % cur_len)];
    end

    // Peripheral model: latch mosi on sampling edges, count busy and select-high time
    always @(negedge clk) begin
        if (mon_clr) begin
            sbit = 0; busy_cyc = 0; cs_hi_cyc = 0;
            for (int i = 0; i < 8; i++) cap_w[i] = '0;
        end else begin
            if (busy) busy_cyc++;
            if (busy && cs_n) cs_hi_cyc++;
            if (!cs_n && sck != sck_prev && sck == (cpol ^ !cpha)) begin
                if ((sbit / cur_len) < 8)
                    cap_w[sbit / cur_len][cur_len - 1 - (sbit % cur_len)] = mosi;
                sbit++;
            end
        end
        sck_prev = sck;
    end

    // Watchdog: a hung run counts as one more failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); #1 mon_clr = 1'b1;
        @(posedge clk); @(posedge clk); #1 mon_clr = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic pop_rx();
        @(posedge clk); #1 rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) sl_w[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 mosi", {31'd0, mosi}, 32'd0);
        chk("R1 sck", {31'd0, sck}, {31'd0, cpol});
        chk("R1 tx_full", {31'd0, tx_full}, 32'd0);
        chk("R1 rx_empty", {31'd0, rx_empty}, 32'd1);

        // Table of two-word bursts over modes, lengths and dividers
        for (int v = 0; v < NV; v++) begin
            logic [15:0] msk;
            int n, exp_busy;
            n   = int'(VECS[v].len);
            msk = 16'((32'd1 << n) - 1);
            @(posedge clk); #1;
            cpol = VECS[v].cpol; cpha = VECS[v].cpha;
            word_len = VECS[v].len; div_half = VECS[v].div;
            cur_len = n; sl_w[0] = VECS[v].s0; sl_w[1] = VECS[v].s1;
            clear_mon();
            @(posedge clk); #1 wr_en = 1'b1; wr_data = VECS[v].w0;
            @(posedge clk); #1 wr_data = VECS[v].w1;
            @(posedge clk); #1 wr_en = 1'b0;
            wait_idle();
            exp_busy = (4 * n + (VECS[v].cpha ? 2 : 3)) * int'(VECS[v].div);
            chk($sformatf("R3 word0 v%0d", v), {16'd0, cap_w[0]}, {16'd0, VECS[v].w0 & msk});
            chk($sformatf("R2 word1 v%0d", v), {16'd0, cap_w[1]}, {16'd0, VECS[v].w1 & msk});
            chk($sformatf("R3 bitcount v%0d", v), sbit, 2 * n);
            chk($sformatf("R7 R4 busy cycles v%0d", v), busy_cyc, exp_busy);
            if (VECS[v].cpha)
                chk($sformatf("R6 select held v%0d", v), cs_hi_cyc, 0);
            else
                chk($sformatf("R5 select gap v%0d", v), cs_hi_cyc, 3 * int'(VECS[v].div));
            chk($sformatf("R10 end state v%0d", v), {30'd0, cs_n, sck}, {30'd0, 1'b1, cpol});
            chk($sformatf("R9 reply0 v%0d", v), {16'd0, rd_data}, {16'd0, VECS[v].s0 & msk});
            pop_rx();
            chk($sformatf("R9 reply1 v%0d", v), {16'd0, rd_data}, {16'd0, VECS[v].s1 & msk});
            pop_rx();
            chk($sformatf("R9 drained v%0d", v), {31'd0, rx_empty}, 32'd1);
        end

        // Directed: overfill both queues (R8 ignored write, R9 dropped reply)
        @(posedge clk); #1;
        cpol = 1'b0; cpha = 1'b0; word_len = 5'd8; div_half = 8'd4; cur_len = 8;
        for (int i = 0; i < 8; i++) sl_w[i] = 16'(8'h11 * (i + 1));
        clear_mon();
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1 wr_en = 1'b1; wr_data = 16'(8'hA0 + i);
        end
        @(posedge clk); #1 wr_en = 1'b0;
        @(negedge clk);
        chk("R8 tx_full", {31'd0, tx_full}, 32'd1);
        wait_idle();
        chk("R8 words sent", sbit, 5 * 8);
        chk("R8 fifth word", {16'd0, cap_w[4]}, 32'h00A4);
        chk("R8 sixth dropped", {16'd0, cap_w[5]}, 32'd0);
        chk("R9 oldest reply", {16'd0, rd_data}, 32'h0011);
        for (int i = 0; i < 4; i++) pop_rx();
        chk("R9 overflow dropped", {31'd0, rx_empty}, 32'd1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule